// File: doc/BRIEF.md
# Descriptor Ring Frame Mover

The block moves whole frames between a byte-wide memory master port and a pair of byte streams: an outbound stream towards the serial line and an inbound stream from it. Software describes every frame with an 8-byte descriptor in one of two rings in shared memory. The receive ring sits at a 1 KB aligned base. The transmit ring starts 512 bytes above that base. A descriptor holds a buffer address, a byte count and a flags byte. The top bit of the flags byte says who owns the slot.

Software fills a descriptor, sets its ownership bit and writes the prompt register. The engine then reads that descriptor. It streams the buffer out, or stores an incoming frame into the buffer. It writes back the count and the completion flags, clearing ownership, and raises a per-direction interrupt level. It then moves on to the next slot. When it meets a slot that software still holds, that direction stops until the next prompt write. When both directions are disabled, both ring indices return to slot 0.

Top module: `frame_ring_dma`

## Requirements
- R1: Register writes use `reg_addr`: 0 control (bit0 receive enable, bit1 transmit enable), 1 base high (data bits 5:0 give address bits 31:26), 2 base low (data bits 15:0 give address bits 25:10). Descriptor slot i of the receive ring is at base+8*i, and of the transmit ring at base+512+8*i. Slot bytes 0..3 hold the buffer address, least significant byte first, bytes 4 and 5 the count low and high byte, and byte 6 the flags. On completion the engine writes back the count it handled.
- R2: A slot is processed only if flags bit 7 (ownership) is set; the flags written back on completion have bit 7 clear.
- R3: On reading a slot whose bit 7 is clear, that direction halts; a later change of the slot in memory has no effect until a write to register 5 (prompt).
- R4: A transmit slot sends exactly count bytes from its buffer in address order on `tx_data`, with `tx_last` high on the final byte only; a count of 0 sends nothing and still completes.
- R5: A transmit slot with flags bit 4 set holds `tx_nocrc` high for its bytes and keeps bit 4 in the written-back flags. A `tx_abort` seen while a byte is offered sets bit 5 in the written-back flags.
- R6: A receive slot stores incoming bytes at its buffer in order and writes back the number stored. On the last beat `rx_stat` bit0, bit1 and bit2 become flags bit 0 (line error), bit 1 (overrun) and bit 3 (check error). Bit 6 is set when any error bit is set.
- R7: Register 4 holds the maximum frame length. Received bytes beyond it are not stored, the count written back equals the maximum, and flags bits 2 and 6 are set.
- R8: Register 3 bits 11:8 and 15:12 give the receive and transmit ring size codes; a ring has 2^code slots (codes above 6 act as 6), and its index wraps from the last slot to slot 0.
- R9: While control bits 0 and 1 are both 0, both ring indices are held at slot 0.
- R10: Each completion raises `irq_rx` or `irq_tx` as a level that stays high until a write to register 6 clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| irq_rx | output | 1 | Receive completion level |
| irq_tx | output | 1 | Transmit completion level |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request completed (read data valid) |
| mem_rdata | input | 8 | Read byte |
| tx_valid | output | 1 | Outbound byte valid |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Final byte of frame |
| tx_nocrc | output | 1 | Line side must not append a check sequence |
| tx_ready | input | 1 | Line side accepts byte |
| tx_abort | input | 1 | Line side reports a failed frame |
| rx_valid | input | 1 | Inbound byte valid |
| rx_data | input | 8 | Inbound byte |
| rx_last | input | 1 | Final byte of frame |
| rx_stat | input | 3 | Frame status on final byte: line error, overrun, check error |
| rx_ready | output | 1 | Engine accepts inbound byte |

## Verification
A wrong ring index shows as the engine reading a stale slot that software no longer owns. The direction then halts, and the expected interrupt never arrives within the wait window of the very frame that follows. A wrong sequence position or length counter shows at once as missing, repeated or misplaced bytes on the outbound stream, or in the receive buffer. It also shows as a wrong count or flags byte in memory, checked right after the interrupt. Lost pending state shows as a halt where a frame was due, or as a frame sent without a prompt.

// File: rtl/frd_pkg.sv
package frd_pkg;
    localparam int unsigned AW        = 32;
    localparam int unsigned CW        = 16;
    localparam int unsigned SLOT_B    = 8;
    localparam int unsigned TX_OFS    = 512;

    localparam int unsigned F_OWN   = 7;
    localparam int unsigned F_ERR   = 6;
    localparam int unsigned F_TXERR = 5;
    localparam int unsigned F_NOCRC = 4;
    localparam int unsigned F_CHK   = 3;
    localparam int unsigned F_LEN   = 2;
    localparam int unsigned F_OVF   = 1;
    localparam int unsigned F_LINE  = 0;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_HI    = 3'd1;
    localparam logic [2:0] RA_LO    = 3'd2;
    localparam logic [2:0] RA_SIZE  = 3'd3;
    localparam logic [2:0] RA_MAXL  = 3'd4;
    localparam logic [2:0] RA_PRMPT = 3'd5;
    localparam logic [2:0] RA_ICLR  = 3'd6;

    typedef enum logic [2:0] {
        S_IDLE, S_SLOT, S_TFETCH, S_TSEND, S_RWAIT, S_RSTORE, S_WBACK
    } seq_t;

    typedef struct packed {
        seq_t          st;
        logic          dtx;
        logic [2:0]    k;
        logic [AW-1:0] ba;
        logic [CW-1:0] cnt;
        logic [7:0]    fl;
        logic [CW-1:0] pos;
        logic [7:0]    dat;
        logic          lastq;
        logic          e_line;
        logic          e_ovf;
        logic          e_chk;
        logic          e_len;
        logic          e_tx;
        logic          tpend;
        logic          rpend;
        logic          irx;
        logic          itx;
    } seq_s;
endpackage

// File: rtl/frd_regs.sv
module frd_regs
    import frd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [15:0]   wr_data,
    output logic          rx_en,
    output logic          tx_en,
    output logic [AW-1:0] base,
    output logic [3:0]    rx_code,
    output logic [3:0]    tx_code,
    output logic [CW-1:0] maxlen,
    output logic          prompt,
    output logic          iclr
);
    typedef struct packed {
        logic          rxe;
        logic          txe;
        logic [5:0]    hi;
        logic [15:0]   lo;
        logic [3:0]    rc;
        logic [3:0]    tc;
        logic [CW-1:0] ml;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                RA_CTRL: begin
                    r_d.rxe = wr_data[0];
                    r_d.txe = wr_data[1];
                end
                RA_HI:   r_d.hi = wr_data[5:0];
                RA_LO:   r_d.lo = wr_data;
                RA_SIZE: begin
                    r_d.rc = wr_data[11:8];
                    r_d.tc = wr_data[15:12];
                end
                RA_MAXL: r_d.ml = CW'(wr_data);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_en   = r_q.rxe;
    assign tx_en   = r_q.txe;
    assign base    = {r_q.hi, r_q.lo, 10'b0};
    assign rx_code = r_q.rc;
    assign tx_code = r_q.tc;
    assign maxlen  = r_q.ml;
    assign prompt  = wr_en && (wr_addr == RA_PRMPT);
    assign iclr    = wr_en && (wr_addr == RA_ICLR);
endmodule

// File: rtl/frd_idx.sv
module frd_idx #(
    parameter int IW      = 6,
    parameter int MAXCODE = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [3:0]    code,
    output logic [IW-1:0] idx
);
    logic [3:0]    lim;
    logic [IW-1:0] last;
    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        lim   = (code > 4'(MAXCODE)) ? 4'(MAXCODE) : code;
        last  = IW'((32'd1 << lim) - 32'd1);
        idx_d = idx_q;
        if (clr)      idx_d = '0;
        else if (adv) idx_d = (idx_q == last) ? '0 : idx_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;

    a_r9_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (idx == '0));
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && idx == last && $stable(code)) |=> (idx == '0));
endmodule

// File: rtl/frame_ring_dma.sv
module frame_ring_dma
    import frd_pkg::*;
#(
    parameter int IW      = 6,
    parameter int MAXCODE = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic          irq_rx,
    output logic          irq_tx,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          tx_nocrc,
    input  logic          tx_ready,
    input  logic          tx_abort,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic [2:0]    rx_stat,
    output logic          rx_ready
);
    logic          rx_en, tx_en, prompt, iclr, clr;
    logic [AW-1:0] base;
    logic [3:0]    code_v [2];
    logic [CW-1:0] maxlen;
    logic          adv_v  [2];
    logic [IW-1:0] idx_v  [2];

    frd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .rx_en(rx_en), .tx_en(tx_en), .base(base),
        .rx_code(code_v[0]), .tx_code(code_v[1]), .maxlen(maxlen),
        .prompt(prompt), .iclr(iclr)
    );

    assign clr = !rx_en && !tx_en;

    // index 0: receive ring, index 1: transmit ring
    for (genvar g = 0; g < 2; g++) begin : g_ring
        frd_idx #(.IW(IW), .MAXCODE(MAXCODE)) u_idx (
            .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv_v[g]),
            .code(code_v[g]), .idx(idx_v[g])
        );
    end

    seq_s          s_d, s_q;
    logic [AW-1:0] slot_addr;
    logic [7:0]    fl_out;
    logic          any_err;

    always_comb begin
        slot_addr = base + (s_q.dtx ? AW'(TX_OFS) : '0)
                  + (AW'(s_q.dtx ? idx_v[1] : idx_v[0]) * AW'(SLOT_B));
        any_err   = s_q.e_line | s_q.e_ovf | s_q.e_chk | s_q.e_len;
        if (s_q.dtx) begin
            fl_out          = s_q.fl;
            fl_out[F_OWN]   = 1'b0;
            fl_out[F_TXERR] = s_q.fl[F_TXERR] | s_q.e_tx;
        end else begin
            fl_out         = '0;
            fl_out[F_ERR]  = any_err;
            fl_out[F_CHK]  = s_q.e_chk;
            fl_out[F_LEN]  = s_q.e_len;
            fl_out[F_OVF]  = s_q.e_ovf;
            fl_out[F_LINE] = s_q.e_line;
        end
    end

    always_comb begin
        s_d       = s_q;
        adv_v[0]  = 1'b0;
        adv_v[1]  = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                s_d.k      = '0;
                s_d.e_line = 1'b0;
                s_d.e_ovf  = 1'b0;
                s_d.e_chk  = 1'b0;
                s_d.e_len  = 1'b0;
                s_d.e_tx   = 1'b0;
                s_d.lastq  = 1'b0;
                if (tx_en && s_q.tpend) begin
                    s_d.dtx = 1'b1;
                    s_d.st  = S_SLOT;
                end else if (rx_en && s_q.rpend) begin
                    s_d.dtx = 1'b0;
                    s_d.st  = S_SLOT;
                end
            end
            S_SLOT: if (mem_ack) begin
                case (s_q.k)
                    3'd4:    s_d.cnt[7:0]  = mem_rdata;
                    3'd5:    s_d.cnt[15:8] = mem_rdata;
                    3'd6:    s_d.fl        = mem_rdata;
                    default: s_d.ba[8*s_q.k[1:0] +: 8] = mem_rdata;
                endcase
                s_d.k = s_q.k + 3'd1;
                if (s_q.k == 3'd6) begin
                    s_d.k   = '0;
                    s_d.pos = '0;
                    if (!mem_rdata[F_OWN]) begin
                        s_d.st = S_IDLE;
                        if (s_q.dtx) s_d.tpend = 1'b0;
                        else         s_d.rpend = 1'b0;
                    end else if (s_q.dtx) begin
                        s_d.st = (s_q.cnt == '0) ? S_WBACK : S_TFETCH;
                    end else begin
                        s_d.st = S_RWAIT;
                    end
                end
            end
            S_TFETCH: if (mem_ack) begin
                s_d.dat = mem_rdata;
                s_d.st  = S_TSEND;
            end
            S_TSEND: begin
                if (tx_abort) s_d.e_tx = 1'b1;
                if (tx_ready) begin
                    s_d.pos = s_q.pos + 1'b1;
                    s_d.st  = (s_q.pos + 1'b1 == s_q.cnt) ? S_WBACK : S_TFETCH;
                end
            end
            S_RWAIT: if (rx_valid) begin
                s_d.dat   = rx_data;
                s_d.lastq = rx_last;
                if (rx_last) begin
                    s_d.e_line = rx_stat[0];
                    s_d.e_ovf  = rx_stat[1];
                    s_d.e_chk  = rx_stat[2];
                end
                if (s_q.pos < maxlen) s_d.st = S_RSTORE;
                else begin
                    s_d.e_len = 1'b1;
                    if (rx_last) s_d.st = S_WBACK;
                end
            end
            S_RSTORE: if (mem_ack) begin
                s_d.pos = s_q.pos + 1'b1;
                s_d.st  = s_q.lastq ? S_WBACK : S_RWAIT;
            end
            S_WBACK: if (mem_ack) begin
                s_d.k = s_q.k + 3'd1;
                if (s_q.k == 3'd2) begin
                    s_d.st = S_IDLE;
                    if (s_q.dtx) begin
                        s_d.itx  = 1'b1;
                        adv_v[1] = 1'b1;
                    end else begin
                        s_d.irx  = 1'b1;
                        adv_v[0] = 1'b1;
                    end
                end
            end
            default: s_d.st = S_IDLE;
        endcase
        if (clr) s_d.st = S_IDLE;
        if (prompt) begin
            s_d.tpend = 1'b1;
            s_d.rpend = 1'b1;
        end
        if (iclr) begin
            s_d.irx = 1'b0;
            s_d.itx = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        mem_req   = s_q.st inside {S_SLOT, S_TFETCH, S_RSTORE, S_WBACK};
        mem_we    = s_q.st inside {S_RSTORE, S_WBACK};
        mem_addr  = '0;
        mem_wdata = '0;
        case (s_q.st)
            S_SLOT:   mem_addr = slot_addr + AW'(s_q.k);
            S_TFETCH: mem_addr = s_q.ba + AW'(s_q.pos);
            S_RSTORE: begin
                mem_addr  = s_q.ba + AW'(s_q.pos);
                mem_wdata = s_q.dat;
            end
            S_WBACK: begin
                mem_addr  = slot_addr + AW'(4) + AW'(s_q.k);
                mem_wdata = (s_q.k == 3'd0) ? s_q.pos[7:0] :
                            (s_q.k == 3'd1) ? s_q.pos[15:8] : fl_out;
            end
            default: ;
        endcase
    end

    assign tx_valid = (s_q.st == S_TSEND);
    assign tx_data  = s_q.dat;
    assign tx_last  = tx_valid && (s_q.pos + 1'b1 == s_q.cnt);
    assign tx_nocrc = tx_valid && s_q.fl[F_NOCRC];
    assign rx_ready = (s_q.st == S_RWAIT);
    assign irq_rx   = s_q.irx;
    assign irq_tx   = s_q.itx;

    a_r10_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx && !iclr) |=> irq_rx);
    a_r10_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tx && !iclr) |=> irq_tx);
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !clr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    a_r4_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !clr) |=> (tx_valid && $stable(tx_data)));
    a_r7_store_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && s_q.st == S_RSTORE) |-> (s_q.pos < maxlen));
    a_r2_own_returned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && s_q.st == S_WBACK && s_q.k == 3'd2) |-> !mem_wdata[F_OWN]);
endmodule

// File: tb/frame_ring_dma_test.sv
`timescale 1ns/1ps
module frame_ring_dma_test;
    logic clk = 0, rst_n = 0;
    logic reg_wr = 0; logic [2:0] reg_addr = 0; logic [15:0] reg_wdata = 0;
    logic irq_rx, irq_tx, mem_req, mem_we, mem_ack = 0;
    logic [31:0] mem_addr; logic [7:0] mem_wdata, mem_rdata = 0;
    logic tx_valid, tx_last, tx_nocrc, tx_ready = 1, tx_abort = 0;
    logic [7:0] tx_data;
    logic rx_valid = 0, rx_last = 0, rx_ready; logic [7:0] rx_data = 0; logic [2:0] rx_stat = 0;

    frame_ring_dma uut (.*);

    always #10 clk = ~clk;

    logic [7:0] mem [0:4095];
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[11:0]] = mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:0]];
        end else mem_ack <= 1'b0;
    end

    logic [7:0] cap_d [0:255]; logic cap_l [0:255]; logic cap_c [0:255];
    int cap_n = 0;
    always @(posedge clk) if (rst_n && tx_valid && tx_ready) begin
        cap_d[cap_n] = tx_data; cap_l[cap_n] = tx_last; cap_c[cap_n] = tx_nocrc;
        cap_n = cap_n + 1;
    end

    int rdy_mode = 0;
    always @(negedge clk)
        tx_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ($urandom % 3 != 0) : 1'b0;

    int checks = 0, errors = 0;
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_txfl(input logic [7:0] f, input bit ab);
        return (f & 8'h7f) | (ab ? 8'h20 : 8'h00);
    endfunction
    function automatic logic [7:0] exp_rxfl(input logic [2:0] st, input bit le);
        return {1'b0, (|st) | le, 2'b00, st[2], le, st[1], st[0]};
    endfunction

    task automatic reg_w(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    function automatic int slot(input bit tx, input int i);
        return 32'h400 + (tx ? 512 : 0) + i * 8;
    endfunction

    task automatic put_slot(input bit tx, input int i, input int b, input int c, input logic [7:0] f);
        int a = slot(tx, i);
        mem[a] = b[7:0]; mem[a+1] = b[15:8]; mem[a+2] = b[23:16]; mem[a+3] = b[31:24];
        mem[a+4] = c[7:0]; mem[a+5] = c[15:8]; mem[a+6] = f;
    endtask

    task automatic wait_irq(input bit tx, output bit got);
        int t = 0;
        got = 0;
        while (t < 3000) begin
            @(negedge clk);
            if (tx ? irq_tx : irq_rx) begin got = 1; break; end
            t++;
        end
    endtask

    task automatic clear_irq(input bit tx);
        repeat (5) @(negedge clk);
        chk(tx ? irq_tx : irq_rx, "R10 level held", 0, 1);
        reg_w(3'd6, 16'h0);
        chk(!(tx ? irq_tx : irq_rx), "R10 cleared", 1, 0);
        repeat (40) @(negedge clk);
    endtask

    task automatic do_tx(input int i, input int len, input bit nc, input bit ab);
        int b = 32'h800 + i * 32;
        int start = cap_n;
        bit got;
        logic [7:0] f = 8'h80 | (nc ? 8'h10 : 8'h00);
        for (int j = 0; j < len; j++) mem[b+j] = 8'($urandom);
        put_slot(1, i, b, len, f);
        rdy_mode = ab ? 2 : 1;
        reg_w(3'd5, 16'h0);
        if (ab) begin
            int t = 0;
            while (!tx_valid && t < 500) begin @(negedge clk); t++; end
            tx_abort = 1; @(negedge clk); tx_abort = 0; rdy_mode = 0;
        end
        wait_irq(1, got);
        rdy_mode = 0;
        chk(got, "R4 tx completion", got, 1);
        chk(cap_n - start == len, "R4 byte count", cap_n - start, len);
        for (int j = 0; j < len && start + j < cap_n; j++) begin
            chk(cap_d[start+j] == mem[b+j], "R4 tx data", cap_d[start+j], mem[b+j]);
            chk(cap_l[start+j] == (j == len - 1), "R4 tx last", cap_l[start+j], j == len - 1);
            chk(cap_c[start+j] == nc, "R5 nocrc", cap_c[start+j], nc);
        end
        chk(mem[slot(1,i)+4] == 8'(len) && mem[slot(1,i)+5] == 8'h0, "R1 count writeback",
            mem[slot(1,i)+4], len);
        chk(mem[slot(1,i)+6] == exp_txfl(f, ab), "R2 R5 tx flags", mem[slot(1,i)+6], exp_txfl(f, ab));
        if (got) clear_irq(1);
    endtask

    logic [7:0] rx_pat [0:15];
    task automatic send_rx(input int n, input logic [2:0] st);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            rx_valid = 1; rx_data = rx_pat[j]; rx_last = (j == n - 1);
            rx_stat = (j == n - 1) ? st : 3'b0;
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk); rx_valid = 0; rx_last = 0; rx_stat = 0;
    endtask

    task automatic do_rx(input int i, input int n, input logic [2:0] st);
        int b = 32'hC00 + i * 32;
        int s = (n < 6) ? n : 6;
        bit le = (n > 6);
        bit got;
        for (int j = 0; j < 20; j++) mem[b+j] = 8'hEE;
        for (int j = 0; j < n; j++) rx_pat[j] = 8'($urandom);
        put_slot(0, i, b, 0, 8'h80);
        reg_w(3'd5, 16'h0);
        send_rx(n, st);
        wait_irq(0, got);
        chk(got, "R6 rx completion", got, 1);
        for (int j = 0; j < s; j++)
            chk(mem[b+j] == rx_pat[j], "R6 rx data", mem[b+j], rx_pat[j]);
        chk(mem[b+s] == 8'hEE, "R7 no store past limit", mem[b+s], 8'hEE);
        chk(mem[slot(0,i)+4] == 8'(s) && mem[slot(0,i)+5] == 8'h0, "R6 R7 rx count",
            mem[slot(0,i)+4], s);
        chk(mem[slot(0,i)+6] == exp_rxfl(st, le), "R2 R6 R7 rx flags", mem[slot(0,i)+6], exp_rxfl(st, le));
        if (got) clear_irq(0);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        int txi = 0, rxi = 0, start;
        bit got;
        void'($urandom(32'd7001));
        for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
        repeat (4) @(negedge clk);
        chk(!irq_rx && !irq_tx, "R10 reset irq", irq_rx | irq_tx, 0);
        chk(!mem_req && !tx_valid && !rx_ready, "R2 reset idle", mem_req | tx_valid | rx_ready, 0);
        rst_n = 1;
        reg_w(3'd1, 16'h0); reg_w(3'd2, 16'h1);
        reg_w(3'd3, 16'h2200); reg_w(3'd4, 16'd6); reg_w(3'd0, 16'h3);
        repeat (20) @(negedge clk);
        chk(!mem_req && !tx_valid, "R3 idle before prompt", mem_req, 0);

        for (int n = 0; n < 6; n++) begin // R8 wrap of a 4-slot ring
            do_tx(txi, 1 + $urandom % 5, $urandom % 2, 0);
            txi = (txi + 1) % 4;
        end
        do_tx(txi, 0, 0, 0); txi = (txi + 1) % 4;     // R4 zero length
        do_tx(txi, 3, 1, 1); txi = (txi + 1) % 4;     // R5 abort

        // R3: slot not owned halts until prompt
        put_slot(1, txi, 32'h900, 2, 8'h00);
        mem[32'h900] = 8'h5A; mem[32'h901] = 8'hA5;
        start = cap_n;
        reg_w(3'd5, 16'h0);
        repeat (60) @(negedge clk);
        chk(cap_n == start && !irq_tx, "R3 not owned ignored", cap_n - start, 0);
        mem[slot(1, txi)+6] = 8'h80;
        repeat (60) @(negedge clk);
        chk(cap_n == start && !irq_tx, "R3 no repoll without prompt", cap_n - start, 0);
        reg_w(3'd5, 16'h0);
        wait_irq(1, got);
        chk(got && cap_n - start == 2, "R3 resumes on prompt", cap_n - start, 2);
        if (got) clear_irq(1);
        txi = (txi + 1) % 4;

        for (int n = 0; n < 5; n++) begin
            do_rx(rxi, 1 + $urandom % 5, 3'($urandom % 8));
            rxi = (rxi + 1) % 4;
        end
        do_rx(rxi, 9, 3'b000); rxi = (rxi + 1) % 4;   // R7 over limit
        do_rx(rxi, 6, 3'b100); rxi = (rxi + 1) % 4;   // R7 exactly at limit

        // R9: disabling both directions returns indices to slot 0
        chk(txi != 0 && rxi != 0, "R9 indices away from zero", txi, 1);
        reg_w(3'd0, 16'h0); repeat (3) @(negedge clk); reg_w(3'd0, 16'h3);
        do_tx(0, 2, 0, 0);
        do_rx(0, 3, 3'b001);
        finish_run();
    end
endmodule